// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits on the write path of a sector-programmed flash array. It watches every accepted write cycle, a pair of address and data, and looks for a fixed three-write command. Two key writes open the command, and the third write selects the action. The action is a single-cycle grant that hands the following writes to the sector loader, entry into the identification mode, or exit from it. A change of identification mode takes effect only after a programmable settle time.

While identification mode is on, a read of address 0 or 1 returns a fixed manufacturer or device code. Every other read passes the array data through. A write that is not part of a valid command stores nothing. It still starts a dummy busy period, during which a host would see polling status. While the loader is busy, or during the grant cycle itself, writes belong to the loader, and the decoder ignores them.

Top module: `unlock_decoder`

## Requirements
- R1: After reset, `prog_en`, `id_mode` and `dummy_busy` are 0, and `rd_data` equals `arr_rdata`.
- R2: The three writes 0xAA to 0x5555, 0x55 to 0x2AAA and 0xA0 to 0x5555 raise `prog_en` for exactly the one cycle after the clock edge that samples the third write. None of these writes starts a dummy busy period.
- R3: The same two key writes followed by 0x90 to 0x5555 set `id_mode` to 1 exactly PAUSE_CYC clock edges after the edge that samples the third write. `id_mode` stays unchanged before that edge.
- R4: The same two key writes followed by 0xF0 to 0x5555 clear `id_mode` exactly PAUSE_CYC clock edges after the edge that samples the third write.
- R5: With `id_mode` at 1 and `rd_addr[14:1]` at zero, `rd_data` is 0x1F when `rd_addr[0]` is 0 and 0xBC when it is 1. At any other address, or with `id_mode` at 0, `rd_data` equals `arr_rdata`.
- R6: A write that is neither the expected next step nor 0xAA to 0x5555 is a stray write. It raises `dummy_busy` from the cycle after it is sampled, for exactly BUSY_CYC cycles, and it raises no `prog_en`. A further stray write restarts the full period.
- R7: A wrong address or wrong data at any step, including a third write that carries an unknown code or sits at the wrong address, returns the decoder to idle. That write counts as a stray write.
- R8: A write of 0xAA to 0x5555 at any step restarts the sequence at its second step without starting a busy period.
- R9: Writes sampled while `ldr_busy` is 1 are ignored. They start no busy period and do not disturb a partly entered sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One write cycle is sampled on each edge where this is high |
| wr_addr | input | 15 | Write address |
| wr_data | input | 8 | Write data |
| ldr_busy | input | 1 | Sector loader owns the write stream |
| rd_addr | input | 15 | Read address |
| arr_rdata | input | 8 | Data read from the array |
| rd_data | output | 8 | Read data after the identification overlay |
| prog_en | output | 1 | One-cycle grant of a sector program operation |
| id_mode | output | 1 | Identification mode is active |
| dummy_busy | output | 1 | Busy period started by a stray write |

## Verification
A table of short write bursts drives the decoder. The bursts cover a clean program command, an unknown third code, corrupted data in the second key, a wrong address in the first key and in the third write, a repeated first key, and a lone second key. Each burst tells granting apart from the stray-write timer. Directed tests add the identification entry and exit with their exact settle edge, and the code overlay at the two identification addresses and at neighbouring addresses. They also measure the busy length and its restart, and confirm that writes made while the loader is busy leave a half-entered command intact.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        addr_t addr;
        byte_t data;
    } wbeat_t;

    localparam addr_t KEY_ADDR_A = 15'h5555;
    localparam addr_t KEY_ADDR_B = 15'h2AAA;
    localparam byte_t KEY_DATA_A = 8'hAA;
    localparam byte_t KEY_DATA_B = 8'h55;
    localparam byte_t OP_PROG    = 8'hA0;
    localparam byte_t OP_ID_ON   = 8'h90;
    localparam byte_t OP_ID_OFF  = 8'hF0;
    localparam byte_t MFR_CODE   = 8'h1F;
    localparam byte_t DEV_CODE   = 8'hBC;

    typedef enum logic [1:0] {SQ_IDLE, SQ_GOT1, SQ_GOT2} sq_e;
    typedef enum logic [2:0] {CM_NONE, CM_PROG, CM_ID_ON, CM_ID_OFF, CM_STRAY} cm_e;

    function automatic logic beat_is(wbeat_t b, addr_t a, byte_t d);
        return (b.addr == a) && (b.data == d);
    endfunction
endpackage

// File: rtl/cmdseq_fsm.sv
module cmdseq_fsm
    import cmdseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  wbeat_t beat,
    input  logic   hold,
    output cm_e    cmd
);
    sq_e  st_q, st_d;
    logic acc, is_k1, is_k2, at_a;

    assign acc   = wr_en && !hold;
    assign is_k1 = beat_is(beat, KEY_ADDR_A, KEY_DATA_A);
    assign is_k2 = beat_is(beat, KEY_ADDR_B, KEY_DATA_B);
    assign at_a  = (beat.addr == KEY_ADDR_A);

    always_comb begin
        st_d = st_q;
        cmd  = CM_NONE;
        if (acc) begin
            unique case (st_q)
                SQ_IDLE: begin
                    if (is_k1) st_d = SQ_GOT1;
                    else       cmd  = CM_STRAY;
                end
                SQ_GOT1: begin
                    if (is_k2)      st_d = SQ_GOT2;
                    else if (is_k1) st_d = SQ_GOT1;
                    else begin
                        st_d = SQ_IDLE;
                        cmd  = CM_STRAY;
                    end
                end
                SQ_GOT2: begin
                    st_d = SQ_IDLE;
                    if (at_a && beat.data == OP_PROG)        cmd  = CM_PROG;
                    else if (at_a && beat.data == OP_ID_ON)  cmd  = CM_ID_ON;
                    else if (at_a && beat.data == OP_ID_OFF) cmd  = CM_ID_OFF;
                    else if (is_k1)                          st_d = SQ_GOT1;
                    else                                     cmd  = CM_STRAY;
                end
                default: st_d = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= SQ_IDLE;
        else     st_q <= st_d;
    end

    AST_HOLD_KEEPS_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hold) |=> $stable(st_q)); // R9
    AST_PROG_AFTER_KEYS: assert property (@(posedge clk) disable iff (rst)
        (cmd == CM_PROG) |-> (st_q == SQ_GOT2)); // R2
    AST_QUIET_NO_CMD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (cmd == CM_NONE)); // R7
endmodule

// File: rtl/cmdseq_id_hold.sv
module cmdseq_id_hold
    import cmdseq_pkg::*;
#(
    parameter int PAUSE_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  cm_e  cmd,
    output logic id_mode
);
    localparam int CW = $clog2(PAUSE_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          pend_q, tgt_q, id_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            tgt_q  <= 1'b0;
            id_q   <= 1'b0;
        end else if (cmd == CM_ID_ON || cmd == CM_ID_OFF) begin
            pend_q <= 1'b1;
            tgt_q  <= (cmd == CM_ID_ON);
            cnt_q  <= CW'(PAUSE_CYC - 1);
        end else if (pend_q) begin
            if (cnt_q == '0) begin
                id_q   <= tgt_q;
                pend_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    assign id_mode = id_q;

    AST_ID_MOVES_AT_END: assert property (@(posedge clk) disable iff (rst)
        (id_q != $past(id_q)) |-> ($past(pend_q) && $past(cnt_q) == '0)); // R3
    AST_ID_TARGET_KEPT: assert property (@(posedge clk) disable iff (rst)
        (pend_q && cmd == CM_NONE) |=> (tgt_q == $past(tgt_q))); // R4
endmodule

// File: rtl/cmdseq_busy_timer.sv
module cmdseq_busy_timer #(
    parameter int BUSY_CYC = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic busy
);
    localparam int BW = $clog2(BUSY_CYC + 1);

    logic [BW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (kick)         cnt_q <= BW'(BUSY_CYC);
        else if (cnt_q != '0)  cnt_q <= cnt_q - BW'(1);
    end

    assign busy = (cnt_q != '0);

    AST_BUSY_NEEDS_KICK: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(kick)); // R6
    AST_BUSY_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0 && !kick) |=> (cnt_q == $past(cnt_q) - BW'(1))); // R6
endmodule

// File: rtl/unlock_decoder.sv
module unlock_decoder
    import cmdseq_pkg::*;
#(
    parameter int PAUSE_CYC = 40,
    parameter int BUSY_CYC  = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [14:0] wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        ldr_busy,
    input  logic [14:0] rd_addr,
    input  logic [7:0]  arr_rdata,
    output logic [7:0]  rd_data,
    output logic        prog_en,
    output logic        id_mode,
    output logic        dummy_busy
);
    wbeat_t beat;
    cm_e    cmd;
    logic   prog_q;

    assign beat = '{addr: wr_addr, data: wr_data};

    cmdseq_fsm u_fsm (
        .clk  (clk),
        .rst  (rst),
        .wr_en(wr_en),
        .beat (beat),
        .hold (ldr_busy | prog_q),
        .cmd  (cmd)
    );

    cmdseq_id_hold #(.PAUSE_CYC(PAUSE_CYC)) u_id (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .id_mode(id_mode)
    );

    cmdseq_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
        .clk (clk),
        .rst (rst),
        .kick(cmd == CM_STRAY),
        .busy(dummy_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) prog_q <= 1'b0;
        else     prog_q <= (cmd == CM_PROG);
    end

    assign prog_en = prog_q;

    always_comb begin
        rd_data = arr_rdata;
        if (id_mode && rd_addr[ADDR_W-1:1] == '0)
            rd_data = rd_addr[0] ? DEV_CODE : MFR_CODE;
    end

    AST_PROG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        prog_q |=> !prog_q); // R2
    AST_ARRAY_WHEN_NORMAL: assert property (@(posedge clk) disable iff (rst)
        !id_mode |-> (rd_data == arr_rdata)); // R5
endmodule

// File: tb/sim_unlock_decoder.sv
`timescale 1ns/1ps
module sim_unlock_decoder;
    localparam int P = 40;
    localparam int B = 25;
    localparam int NV = 7;

    // each word: {valid, addr[14:0], data[7:0]}
    localparam logic [23:0] VSEQ [NV][4] = '{
        '{{1'b1,15'h5555,8'hAA},{1'b1,15'h2AAA,8'h55},{1'b1,15'h5555,8'hA0},24'h0}, // R2
        '{{1'b1,15'h5555,8'hAA},{1'b1,15'h2AAA,8'h55},{1'b1,15'h5555,8'hA1},24'h0}, // R7
        '{{1'b1,15'h5555,8'hAA},{1'b1,15'h2AAA,8'h54},{1'b1,15'h5555,8'hA0},24'h0}, // R7
        '{{1'b1,15'h5554,8'hAA},{1'b1,15'h2AAA,8'h55},{1'b1,15'h5555,8'hA0},24'h0}, // R6
        '{{1'b1,15'h5555,8'hAA},{1'b1,15'h5555,8'hAA},{1'b1,15'h2AAA,8'h55},{1'b1,15'h5555,8'hA0}}, // R8
        '{{1'b1,15'h2AAA,8'h55},24'h0,24'h0,24'h0}, // R6
        '{{1'b1,15'h5555,8'hAA},{1'b1,15'h2AAA,8'h55},{1'b1,15'h2AAA,8'hA0},24'h0}  // R7
    };
    // {expected prog_en, expected dummy_busy} right after the last write
    localparam logic [1:0] VEXP [NV] = '{2'b10, 2'b01, 2'b01, 2'b01, 2'b10, 2'b01, 2'b01};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        ldr_busy = 1'b0;
    logic [14:0] rd_addr = '0;
    logic [7:0]  arr_rdata = 8'h5A;
    logic [7:0]  rd_data;
    logic        prog_en, id_mode, dummy_busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    unlock_decoder #(.PAUSE_CYC(P), .BUSY_CYC(B)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ldr_busy(ldr_busy), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
        .rd_data(rd_data), .prog_en(prog_en), .id_mode(id_mode), .dummy_busy(dummy_busy)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (B + 3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 prog_en", {7'b0, prog_en}, 8'h0);
        chk("R1 id_mode", {7'b0, id_mode}, 8'h0);
        chk("R1 dummy_busy", {7'b0, dummy_busy}, 8'h0);
        chk("R1 rd_data", rd_data, 8'h5A);

        // table of write bursts
        for (int v = 0; v < NV; v++) begin
            for (int s = 0; s < 4; s++)
                if (VSEQ[v][s][23]) do_wr(VSEQ[v][s][22:8], VSEQ[v][s][7:0]);
            chk($sformatf("R2/R6/R7/R8 vec%0d prog", v), {7'b0, prog_en}, {7'b0, VEXP[v][1]});
            chk($sformatf("R2/R6/R7/R8 vec%0d busy", v), {7'b0, dummy_busy}, {7'b0, VEXP[v][0]});
            @(negedge clk);
            chk($sformatf("R2 vec%0d pulse end", v), {7'b0, prog_en}, 8'h0);
            settle();
        end

        // R6 busy length
        do_wr(15'h1234, 8'h77);
        chk("R6 busy start", {7'b0, dummy_busy}, 8'h1);
        repeat (B - 1) @(negedge clk);
        chk("R6 busy last", {7'b0, dummy_busy}, 8'h1);
        @(negedge clk);
        chk("R6 busy over", {7'b0, dummy_busy}, 8'h0);

        // R6 restart by a second stray write
        do_wr(15'h0001, 8'h01);
        repeat (5) @(negedge clk);
        do_wr(15'h0002, 8'h02);
        repeat (B - 1) @(negedge clk);
        chk("R6 restart still busy", {7'b0, dummy_busy}, 8'h1);
        @(negedge clk);
        chk("R6 restart over", {7'b0, dummy_busy}, 8'h0);

        // R9 writes during loader busy are ignored
        do_wr(15'h5555, 8'hAA);
        do_wr(15'h2AAA, 8'h55);
        ldr_busy = 1'b1;
        do_wr(15'h3333, 8'h12);
        chk("R9 no busy", {7'b0, dummy_busy}, 8'h0);
        ldr_busy = 1'b0;
        do_wr(15'h5555, 8'hA0);
        chk("R9 sequence kept", {7'b0, prog_en}, 8'h1);
        settle();

        // R3 identification entry
        do_wr(15'h5555, 8'hAA);
        do_wr(15'h2AAA, 8'h55);
        do_wr(15'h5555, 8'h90);
        chk("R3 not yet", {7'b0, id_mode}, 8'h0);
        chk("R3 no busy", {7'b0, dummy_busy}, 8'h0);
        repeat (P - 1) @(negedge clk);
        chk("R3 edge before", {7'b0, id_mode}, 8'h0);
        @(negedge clk);
        chk("R3 entered", {7'b0, id_mode}, 8'h1);

        // R5 overlay
        rd_addr = 15'h0000; #1;
        chk("R5 mfr code", rd_data, 8'h1F);
        rd_addr = 15'h0001; #1;
        chk("R5 dev code", rd_data, 8'hBC);
        rd_addr = 15'h0002; #1;
        chk("R5 addr2 passes", rd_data, 8'h5A);
        rd_addr = 15'h4001; arr_rdata = 8'h3C; #1;
        chk("R5 high addr passes", rd_data, 8'h3C);
        rd_addr = 15'h0000; arr_rdata = 8'h5A;

        // R4 identification exit
        do_wr(15'h5555, 8'hAA);
        do_wr(15'h2AAA, 8'h55);
        do_wr(15'h5555, 8'hF0);
        chk("R4 still on", {7'b0, id_mode}, 8'h1);
        repeat (P - 1) @(negedge clk);
        chk("R4 edge before", {7'b0, id_mode}, 8'h1);
        @(negedge clk);
        chk("R4 exited", {7'b0, id_mode}, 8'h0);
        #1;
        chk("R5 normal read at 0", rd_data, 8'h5A);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule